// File: doc/BRIEF.md
# Single-Word SPI Master with Start/Busy Handshake

This block shifts one 17-bit word out to a serial peripheral while shifting a 17-bit reply in, as a full-duplex SPI master. A controller that polls a two-channel serial ADC uses it in a loop. The controller presents the next command word and pulses `start_i` for one cycle. It then waits for `busy_o` to fall and reads the reply from `rx_data_o`. In the command word, the ADC expects its control bits in the upper bits and zeros below them. The engine itself treats all 17 bits as opaque data.

The serial clock comes from dividing the system clock. Each SCLK half-period lasts `DIV` system cycles. A frame is 36 half-periods long:

- One setup half-period with chip select already low and SCLK still at its rest level.
- 34 SCLK edges.
- One hold half-period with SCLK at rest.
- One half-period with chip select released.

The clock polarity and the sampling phase are latched from the inputs when a transfer starts.

Top module: `spi_master_engine`

## Requirements
- R1: A one-cycle `start_i` while `busy_o` is low starts a transfer. `busy_o` is high and `cs_no` is low in the cycle after the pulse, and `tx_data_i` is captured in that same cycle.
- R2: A `start_i` pulse while `busy_o` is high is ignored. The frame in progress keeps its length and its transmit data, and no second transfer follows it.
- R3: `busy_o` stays high for exactly 36*DIV cycles. `cs_no` stays low for the first 35*DIV of those cycles and is high for the final DIV cycles.
- R4: Outside a transfer, `sclk_o` rests at the level given by `cpol_i`. During a transfer it toggles exactly 34 times and ends at the latched rest level.
- R5: The first SCLK edge comes DIV cycles (one half-period) after `cs_no` goes low.
- R6: MOSI carries bit 16 first and bit 0 last. With `cpha_i`=0 the peripheral samples MOSI on the leading edge (the edge that leaves the rest level), and MOSI changes on the trailing edge. With `cpha_i`=1 MOSI changes on the leading edge and is sampled on the trailing edge. Changing `tx_data_i` after the start has no effect.
- R7: MISO is sampled on the same edges on which the peripheral samples MOSI, and the first sampled bit lands in bit 16. `rx_data_o` takes the received word in the same cycle that `busy_o` falls. It holds its value while `busy_o` is low.
- R8: After reset, `cs_no` is 1, `busy_o` is 0, `sclk_o` is 0 and `rx_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle transfer request |
| cpol_i | input | 1 | SCLK rest level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| tx_data_i | input | 17 | Word to transmit, captured at start |
| rx_data_o | output | 17 | Last received word |
| busy_o | output | 1 | Transfer in progress |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Some internal faults show within one frame as a wrong `busy_o` length or a wrong count of SCLK toggles:

- a half-period counter that stops at the wrong value;
- a divider that wraps at the wrong count.

Both can be measured as soon as `busy_o` falls. A sample or shift strobe on the wrong edge shows as a bit-shifted or corrupted word. This appears in the peripheral model's capture of MOSI and in `rx_data_o` at the end of the same frame. A handshake that accepts a start while busy shows as a longer busy window or a second frame within a few cycles of the first one ending.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_XFER = 1'b1
  } eng_state_e;

  // per-cycle strobes from the half-period timer
  typedef struct packed {
    logic lead;        // leading SCLK edge this cycle
    logic trail;       // trailing SCLK edge this cycle
    logic first_edge;  // current half-period is the setup one
    logic last_edge;   // current half-period ends with the final edge
    logic cs_off;      // end of hold half-period
    logic done;        // end of frame
  } edge_t;

endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
  import spi_eng_pkg::*;
#(
  parameter int unsigned DIV  = 2,
  parameter int unsigned BITS = 17
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  run_i,
  input  logic  cpol_i,
  output logic  sclk_o,
  output edge_t edge_o
);

  localparam int unsigned NUM_EDGES = 2 * BITS;
  localparam int unsigned NUM_HP    = NUM_EDGES + 2;
  localparam int unsigned DW        = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned HW        = $clog2(NUM_HP);

  logic [DW-1:0] div_q;
  logic [HW-1:0] hp_q;
  logic          tick;
  logic          in_edges;

  assign tick     = run_i && (div_q == DW'(DIV - 1));
  assign in_edges = hp_q < HW'(NUM_EDGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      hp_q   <= '0;
      sclk_o <= 1'b0;
    end else if (start_i) begin
      div_q  <= '0;
      hp_q   <= '0;
      sclk_o <= cpol_i;
    end else if (run_i) begin
      if (tick) begin
        div_q <= '0;
        hp_q  <= hp_q + 1'b1;
        if (in_edges) sclk_o <= ~sclk_o;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end else begin
      sclk_o <= cpol_i;  // idle level tracks polarity input
    end
  end

  always_comb begin
    edge_o.lead       = tick && in_edges && !hp_q[0];
    edge_o.trail      = tick && in_edges &&  hp_q[0];
    edge_o.first_edge = hp_q == '0;
    edge_o.last_edge  = hp_q == HW'(NUM_EDGES - 1);
    edge_o.cs_off     = tick && (hp_q == HW'(NUM_HP - 2));
    edge_o.done       = tick && (hp_q == HW'(NUM_HP - 1));
  end

  assert_frame_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o.done |-> $past(run_i));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_eng_pkg::*;
#(
  parameter int unsigned BITS = 17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] data_i,
  input  logic            cpha_i,
  input  edge_t           edge_i,
  input  logic            miso_i,
  output logic            mosi_o,
  output logic [BITS-1:0] rx_o
);

  logic [BITS-1:0] tx_q;
  logic [BITS-1:0] rx_q;
  logic            sample;
  logic            shift;

  // cpha=0: sample on leading, shift on trailing (skip final trailing)
  // cpha=1: shift on leading (skip first), sample on trailing
  always_comb begin
    if (cpha_i) begin
      sample = edge_i.trail;
      shift  = edge_i.lead && !edge_i.first_edge;
    end else begin
      sample = edge_i.lead;
      shift  = edge_i.trail && !edge_i.last_edge;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= data_i;
      rx_q <= '0;
    end else begin
      if (shift)  tx_q <= {tx_q[BITS-2:0], 1'b0};
      if (sample) rx_q <= {rx_q[BITS-2:0], miso_i};
    end
  end

  assign mosi_o = tx_q[BITS-1];
  assign rx_o   = rx_q;

  assert_edge_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(edge_i.lead && edge_i.trail));

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned DIV  = 2,
  parameter int unsigned BITS = 17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  input  logic [BITS-1:0] tx_data_i,
  output logic [BITS-1:0] rx_data_o,
  output logic            busy_o,
  output logic            sclk_o,
  output logic            cs_no,
  output logic            mosi_o,
  input  logic            miso_i
);

  eng_state_e      state_q;
  logic            cpol_q;
  logic            cpha_q;
  logic            go;
  edge_t           edges;
  logic            mosi_raw;
  logic [BITS-1:0] rx_shift;

  assign go     = start_i && (state_q == ENG_IDLE);
  assign busy_o = state_q == ENG_XFER;
  assign mosi_o = mosi_raw && !cs_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ENG_IDLE;
      cs_no     <= 1'b1;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      rx_data_o <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (go) begin
          state_q <= ENG_XFER;
          cs_no   <= 1'b0;
          cpol_q  <= cpol_i;
          cpha_q  <= cpha_i;
        end
        ENG_XFER: begin
          if (edges.cs_off) cs_no <= 1'b1;
          if (edges.done) begin
            state_q   <= ENG_IDLE;
            rx_data_o <= rx_shift;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  spi_clk_gen #(.DIV(DIV), .BITS(BITS)) u_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(go),
    .run_i  (busy_o),
    .cpol_i (cpol_i),
    .sclk_o (sclk_o),
    .edge_o (edges)
  );

  spi_shifter #(.BITS(BITS)) u_shifter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(go),
    .data_i(tx_data_i),
    .cpha_i(cpha_q),
    .edge_i(edges),
    .miso_i(miso_i),
    .mosi_o(mosi_raw),
    .rx_o  (rx_shift)
  );

  assert_cs_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);

  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !edges.done) |=> busy_o);

  assert_sclk_rest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (sclk_o == cpol_q));

  assert_setup_half_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> $stable(sclk_o));

  assert_rx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(rx_data_o));

endmodule

// File: tb/spi_master_engine_tb.sv
module spi_master_engine_tb;

  localparam int unsigned DIV  = 3;
  localparam int unsigned BITS = 17;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start = 1'b0;
  logic            cpol = 1'b0;
  logic            cpha = 1'b0;
  logic [BITS-1:0] tx_data = '0;
  logic [BITS-1:0] rx_data;
  logic            busy, sclk, cs_n, mosi;
  logic            miso = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  spi_master_engine #(.DIV(DIV), .BITS(BITS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .cpol_i(cpol), .cpha_i(cpha),
    .tx_data_i(tx_data), .rx_data_o(rx_data), .busy_o(busy), .sclk_o(sclk),
    .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // peripheral model
  logic [BITS-1:0] slv_tx = '0;
  logic [BITS-1:0] slv_rx = '0;
  int              slv_idx = 0;

  always @(negedge cs_n) begin
    slv_rx = '0;
    if (!cpha) begin
      miso    = slv_tx[BITS-1];
      slv_idx = BITS - 2;
    end else begin
      slv_idx = BITS - 1;
    end
  end

  always @(sclk) begin
    if (!cs_n) begin
      if ((sclk != cpol) ^ cpha) begin
        slv_rx = {slv_rx[BITS-2:0], mosi};
      end else if (slv_idx >= 0) begin
        miso    = slv_tx[slv_idx];
        slv_idx = slv_idx - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // one frame with timing measurements; optional start pulse mid-frame
  task automatic do_xfer(input logic [BITS-1:0] tx, input logic [BITS-1:0] sw,
                         input logic pol, input logic pha, input bit inject);
    int busy_cnt = 0, cs_cnt = 0, pre_cnt = 0, toggles = 0;
    bit seen_edge = 0;
    logic prev_sclk;
    logic [BITS-1:0] old_rx, last_busy_rx;
    cpol = pol; cpha = pha; slv_tx = sw; tx_data = tx;
    @(negedge clk);
    old_rx = rx_data;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !cs_n, "R1 busy/cs after start", {busy, cs_n}, 2'b10);
    prev_sclk = pol;
    last_busy_rx = rx_data;
    while (busy && busy_cnt < 10000) begin
      busy_cnt++;
      if (!cs_n) cs_cnt++;
      if (sclk != prev_sclk) begin toggles++; seen_edge = 1; end
      if (!cs_n && !seen_edge) pre_cnt++;
      prev_sclk = sclk;
      last_busy_rx = rx_data;
      if (inject && busy_cnt == 10) begin start = 1'b1; tx_data = ~tx; end
      if (inject && busy_cnt == 11) start = 1'b0;
      @(negedge clk);
    end
    check(busy_cnt == 36 * DIV, "R3 busy length", busy_cnt, 36 * DIV);
    check(cs_cnt == 35 * DIV, "R3 cs low length", cs_cnt, 35 * DIV);
    check(toggles == 34, "R4 sclk toggles", toggles, 34);
    check(sclk == pol, "R4 sclk rest level", sclk, pol);
    check(pre_cnt == DIV, "R5 cs to first edge", pre_cnt, DIV);
    check(slv_rx == tx, "R6 mosi word", slv_rx, tx);
    check(rx_data == sw, "R7 rx word", rx_data, sw);
    check(last_busy_rx == old_rx, "R7 rx unchanged before busy falls", last_busy_rx, old_rx);
    repeat (4 * DIV) @(negedge clk);
    check(!busy && cs_n, "R2 no extra frame", {busy, cs_n}, 2'b01);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R8 cs in reset", cs_n, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R8 busy", busy, 0);
    check(sclk == 1'b0, "R8 sclk", sclk, 0);
    check(rx_data == '0, "R8 rx", rx_data, 0);
    check(cs_n == 1'b1, "R8 cs", cs_n, 1);
  endtask

  task automatic t_mode0();
    do_xfer(17'h1A000, 17'h0ABCD, 1'b0, 1'b0, 1'b0);
    do_xfer(17'h15555, 17'h1FFFF, 1'b0, 1'b0, 1'b0);
    do_xfer(17'h1E000, 17'h10001, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cpol1();
    do_xfer(17'h0F0F0, 17'h13579, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_cpha1();
    do_xfer(17'h1C3A5, 17'h0B1E2, 1'b0, 1'b1, 1'b0);
    do_xfer(17'h10001, 17'h1A5A5, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_busy_start();
    // R2: pulse during frame with changed tx_data, R6 tx captured at start
    do_xfer(17'h12345, 17'h0F00F, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_rx_hold();
    logic [BITS-1:0] held;
    held = rx_data;
    cpol = 1'b1;
    repeat (5) @(negedge clk);
    check(sclk == 1'b1, "R4 idle follows cpol", sclk, 1);
    cpol = 1'b0;
    repeat (20) @(negedge clk);
    check(sclk == 1'b0, "R4 idle low", sclk, 0);
    check(rx_data == held, "R7 rx held while idle", rx_data, held);
    check(cs_n && !busy, "R7 idle cs/busy", {cs_n, busy}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_mode0();
    t_cpol1();
    t_cpha1();
    t_busy_start();
    t_rx_hold();
    report();
  end

endmodule